// File: doc/BRIEF.md
# Shared-Memory Bridge with Posted Writes and Read Prefetch

This block lets a 16-bit host memory bus reach an 8-bit static RAM. The RAM sits on a private bus that other agents also use. An external decoder tells the block when a host cycle targets the shared window. The block then serves the cycle and, when it has to, stretches it by pulling its ready line low.

Host writes land in a one-entry holding register, so the host cycle ends at once; the register is drained to the RAM later. Host reads are answered from a one-word buffer that is tagged with its word address. On a miss, the block fetches both bytes of the word first. Once a read strobe is released, the block fetches the next word up into the buffer, so a host that reads sequentially mostly sees single-cycle hits. Any other use of the private bus, and any posted host write, marks the buffer invalid.

The private bus is shared through a request/grant pair. Every RAM access is made under grant, and each byte takes two clocks. Until a byte-high-enable has been seen on a host cycle, the block works byte-wide towards the host.

Top module: `shm_bridge`

## Requirements
- R1: A host cycle is taken only while its strobe is high, `host_sel` is high and `host_refresh` is low. Otherwise ready stays high and RAM contents are unchanged.
- R2: A write that finds the holding register empty completes with no wait cycle. Its bytes reach the RAM later without further host action.
- R3: A write that finds the holding register still full holds ready low until the old data has been written. It is then accepted.
- R4: While a read is pending and `pb_gnt` is low, `pb_req` is high and ready is low.
- R5: A read miss fetches two bytes, each with `sram_oe` high for two clocks. From the read strobe, ready is released after six clock edges. `sram_oe` and `sram_we` are never high together, and neither is high without grant.
- R6: In a word fetch, the byte at the even address fills bits 7:0 and the byte at the odd address fills bits 15:8.
- R7: On a hit, the word is driven with `host_rdata_oe` high and ready high after one edge. It stays stable until the read strobe drops, and `host_rdata_oe` falls with the strobe.
- R8: After a read ends, the next word address up is fetched between host cycles, so that read then hits.
- R9: A pulse on `other_access` invalidates the buffer; the next read of the buffered word misses.
- R10: An accepted host write invalidates the buffer, and a later read of the written word returns the new data.
- R11: Until `host_bhe` has been high during a taken cycle, reads return the addressed byte on bits 7:0 with bits 15:8 zero. In this mode a write stores `host_wdata[7:0]` at the byte address only.
- R12: After that, writes use byte lanes. The even byte is written when address bit 0 is 0, from bits 7:0. The odd byte is written when address bit 0 is 1 or `host_bhe` is high, from bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_rd | input | 1 | Host memory read strobe |
| host_wr | input | 1 | Host memory write strobe |
| host_refresh | input | 1 | Refresh cycle in progress |
| host_sel | input | 1 | External shared-window decode |
| host_bhe | input | 1 | Host byte-high enable |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 1 | Read data driven |
| host_rdy | output | 1 | Host ready (low stretches the cycle) |
| other_access | input | 1 | Another agent used the private bus |
| pb_req | output | 1 | Private bus request |
| pb_gnt | input | 1 | Private bus grant |
| sram_addr | output | AW | RAM byte address |
| sram_wdata | output | 8 | RAM write data |
| sram_rdata | input | 8 | RAM read data |
| sram_oe | output | 1 | RAM output enable |
| sram_we | output | 1 | RAM write enable |

## Verification
A posted write can arrive while a prefetch or a drain is still using the RAM, so buffer invalidation and a buffer refill can land on the same edge. The bench provokes this by writing to the word just prefetched, then reading it back at once. The result is judged by the returned word, which must be the new data. A second pairing is the drain of a full holding register against the next write. This is provoked by back-to-back writes, and judged by a non-zero stall count and by both words in the RAM model.

// File: rtl/shm_bridge.sv
module shm_bridge #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_refresh,
  input  logic          host_sel,
  input  logic          host_bhe,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          host_rdata_oe,
  output logic          host_rdy,
  input  logic          other_access,
  output logic          pb_req,
  input  logic          pb_gnt,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  input  logic [7:0]    sram_rdata,
  output logic          sram_oe,
  output logic          sram_we
);
  localparam int TW = AW - 1;

  logic          busy, op_wr, ph, bidx, spoil;
  logic [TW-1:0] op_tag;
  logic          hold_v;
  logic [TW-1:0] hold_tag;
  logic [1:0]    hold_mask;
  logic [15:0]   hold_data;
  logic          pf_v, pf_pend;
  logic [TW-1:0] pf_tag, pf_next;
  logic [15:0]   pf_data, rd_q;
  logic          rd_done, wr_done, wide;

  logic          acc_rd, acc_wr, rd_pend, wr_stall, wr_acc, wide_now;
  logic          hit, can_go, serve, fill, pref, flush, last;
  logic [TW-1:0] tag;

  assign acc_rd   = host_rd & host_sel & ~host_refresh;
  assign acc_wr   = host_wr & host_sel & ~host_refresh;
  assign tag      = host_addr[AW-1:1];
  assign wide_now = wide | host_bhe;
  assign rd_pend  = acc_rd & ~rd_done;
  assign wr_stall = acc_wr & ~wr_done & hold_v;
  assign wr_acc   = acc_wr & ~wr_done & ~hold_v;
  assign host_rdy = ~rd_pend & ~wr_stall;

  assign hit    = pf_v && (pf_tag == tag);
  assign can_go = ~busy & ~hold_v & pb_gnt;
  assign serve  = rd_pend & can_go & hit;
  assign fill   = rd_pend & can_go & ~hit;
  assign pref   = pf_pend & ~acc_rd & ~acc_wr & can_go;
  assign flush  = ~busy & hold_v & pb_gnt;
  assign last   = ph & (op_wr ? (bidx | ~hold_mask[1]) : bidx);

  assign pb_req        = busy | hold_v | rd_pend | (pf_pend & ~acc_rd & ~acc_wr);
  assign sram_addr     = {op_tag, bidx};
  assign sram_wdata    = bidx ? hold_data[15:8] : hold_data[7:0];
  assign sram_oe       = busy & ~op_wr;
  assign sram_we       = busy & op_wr & ph;
  assign host_rdata_oe = rd_done & host_rd;
  assign host_rdata    = host_rdata_oe ? rd_q : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_wr <= 1'b0; ph <= 1'b0; bidx <= 1'b0; spoil <= 1'b0;
      op_tag <= '0; hold_v <= 1'b0; hold_tag <= '0; hold_mask <= 2'b00;
      hold_data <= 16'h0000; pf_v <= 1'b0; pf_pend <= 1'b0; pf_tag <= '0;
      pf_next <= '0; pf_data <= 16'h0000; rd_q <= 16'h0000;
      rd_done <= 1'b0; wr_done <= 1'b0; wide <= 1'b0;
    end else begin
      if (host_bhe && (acc_rd || acc_wr)) wide <= 1'b1;

      if (!host_rd) rd_done <= 1'b0;
      else if (serve) begin
        rd_done <= 1'b1;
        rd_q    <= wide_now ? pf_data
                 : {8'h00, host_addr[0] ? pf_data[15:8] : pf_data[7:0]};
        pf_next <= tag + 1'b1;
      end

      if (!host_wr) wr_done <= 1'b0;
      else if (wr_acc) wr_done <= 1'b1;

      if (wr_acc) begin
        hold_v   <= 1'b1;
        hold_tag <= tag;
        if (wide_now) begin
          hold_mask <= {host_bhe | host_addr[0], ~host_addr[0]};
          hold_data <= host_wdata;
        end else begin
          hold_mask <= host_addr[0] ? 2'b10 : 2'b01;
          hold_data <= {host_wdata[7:0], host_wdata[7:0]};
        end
      end

      if (!busy) begin
        if (flush) begin
          busy <= 1'b1; op_wr <= 1'b1; ph <= 1'b0;
          bidx <= ~hold_mask[0]; op_tag <= hold_tag;
        end else if (fill || pref) begin
          busy <= 1'b1; op_wr <= 1'b0; ph <= 1'b0; bidx <= 1'b0;
          op_tag <= fill ? tag : pf_next; spoil <= 1'b0; pf_v <= 1'b0;
        end
        if (pref) pf_pend <= 1'b0;
      end else begin
        ph <= ~ph;
        if (ph && !op_wr) begin
          if (bidx) pf_data[15:8] <= sram_rdata;
          else      pf_data[7:0]  <= sram_rdata;
        end
        if (last) begin
          busy <= 1'b0;
          if (op_wr) hold_v <= 1'b0;
          else begin
            pf_tag <= op_tag;
            pf_v   <= ~spoil;
          end
        end else if (ph) bidx <= 1'b1;
      end

      if (!host_rd && rd_done) pf_pend <= 1'b1;
      if (other_access || wr_acc) spoil <= 1'b1;
      if (other_access || wr_acc || (busy && op_wr && last)) pf_v <= 1'b0;
    end
  end
endmodule

// File: rtl/shm_bridge_chk.sv
module shm_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic        host_refresh,
  input logic        host_sel,
  input logic [15:0] host_rdata,
  input logic        host_rdata_oe,
  input logic        host_rdy,
  input logic        pb_req,
  input logic        pb_gnt,
  input logic        sram_oe,
  input logic        sram_we
);
  assert_unqualified_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_refresh || !host_sel) |-> host_rdy);

  assert_stall_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && !host_refresh && !host_rdata_oe && !pb_gnt) |-> (!host_rdy && pb_req));

  assert_oe_we_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_oe && sram_we));

  assert_ram_under_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_oe || sram_we) |-> pb_gnt);

  assert_read_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata_oe && $past(host_rdata_oe)) |-> $stable(host_rdata));

  assert_strobe_drop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> !host_rdata_oe);
endmodule

bind shm_bridge shm_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_refresh(host_refresh), .host_sel(host_sel), .host_rdata(host_rdata),
  .host_rdata_oe(host_rdata_oe), .host_rdy(host_rdy), .pb_req(pb_req),
  .pb_gnt(pb_gnt), .sram_oe(sram_oe), .sram_we(sram_we)
);

// File: tb/shm_bridge_test.sv
module shm_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 0, host_wr = 0, host_refresh = 0, host_sel = 0, host_bhe = 0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rdata_oe, host_rdy;
  logic other_access = 0;
  logic pb_req, pb_gnt, arb_block = 0;
  logic [15:0] sram_addr;
  logic [7:0] sram_wdata, sram_rdata;
  logic sram_oe, sram_we;

  int checks = 0, errors = 0, oe_cycles = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  always #4 clk = ~clk;

  shm_bridge #(.AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_refresh(host_refresh), .host_sel(host_sel), .host_bhe(host_bhe),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .host_rdy(host_rdy), .other_access(other_access),
    .pb_req(pb_req), .pb_gnt(pb_gnt), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .sram_oe(sram_oe), .sram_we(sram_we));

  assign pb_gnt     = pb_req & ~arb_block;
  assign sram_rdata = sram_oe ? mem[sram_addr[7:0]] : 8'h00;

  always @(posedge clk) begin
    if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;
    if (sram_oe) oe_cycles <= oe_cycles + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read(input logic [15:0] a, input int hold, output logic [15:0] d, output int cnt);
    logic [15:0] first;
    host_addr = a; host_rd = 1; host_sel = 1; host_bhe = 0;
    #1; cnt = 0;
    while (!host_rdy) begin @(negedge clk); cnt++; end
    d = host_rdata; first = host_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(host_rdata == first && host_rdata_oe && host_rdy, "R7 hold", host_rdata, first);
    end
    @(negedge clk);
    host_rd = 0; host_sel = 0;
    #1;
    check(!host_rdata_oe, "R7 release", host_rdata_oe, 0);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] a, input logic [15:0] d, input logic bhe, input logic sel, output int cnt);
    host_addr = a; host_wdata = d; host_bhe = bhe; host_wr = 1; host_sel = sel;
    #1; cnt = 0;
    while (!host_rdy) begin @(negedge clk); cnt++; end
    @(negedge clk);
    host_wr = 0; host_sel = 0; host_bhe = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(host_rdy && !pb_req && !sram_oe && !sram_we && !host_rdata_oe, "R1 reset",
          {host_rdy, pb_req, sram_oe, sram_we, host_rdata_oe}, 5'b10000);
  endtask

  task automatic t_unqualified_r1();
    int cnt;
    host_addr = 16'h0011; host_rd = 1; host_sel = 1; host_refresh = 1;
    repeat (3) @(negedge clk);
    check(host_rdy && !pb_req && !sram_oe, "R1 refresh read ignored", {host_rdy, pb_req, sram_oe}, 3'b100);
    host_rd = 0; host_sel = 0; host_refresh = 0;
    host_write(16'h0004, 16'h00EE, 1'b0, 1'b0, cnt);
    check(cnt == 0, "R1 unselected write no stall", cnt, 0);
  endtask

  task automatic t_narrow_read_r11();
    logic [15:0] d; int cnt, oe0;
    oe0 = oe_cycles;
    host_read(16'h0011, 0, d, cnt);
    check(d == {8'h00, ref_mem[8'h11]}, "R11 narrow read byte", d, {8'h00, ref_mem[8'h11]});
    check(cnt == 6, "R5 miss wait edges", cnt, 6);
    check(oe_cycles - oe0 == 4, "R5 two bytes two clocks each", oe_cycles - oe0, 4);
  endtask

  task automatic t_narrow_write_r2();
    int cnt;
    host_write(16'h0005, 16'h99AB, 1'b0, 1'b1, cnt);
    check(cnt == 0, "R2 posted write no wait", cnt, 0);
    ref_mem[8'h05] = 8'hAB;
    idle(10);
    check(mem[8'h05] == 8'hAB, "R11 narrow write byte", mem[8'h05], 8'hAB);
    check(mem[8'h04] == ref_mem[8'h04], "R1 unselected write no effect", mem[8'h04], ref_mem[8'h04]);
  endtask

  task automatic t_stall_r3();
    int c1, c2;
    host_write(16'h0020, 16'h1234, 1'b1, 1'b1, c1);
    host_write(16'h0022, 16'h5678, 1'b1, 1'b1, c2);
    ref_mem[8'h20] = 8'h34; ref_mem[8'h21] = 8'h12;
    ref_mem[8'h22] = 8'h78; ref_mem[8'h23] = 8'h56;
    check(c1 == 0, "R2 first write no wait", c1, 0);
    check(c2 >= 1, "R3 second write stalled", c2, 1);
    idle(10);
    check({mem[8'h21], mem[8'h20], mem[8'h23], mem[8'h22]} == 32'h12345678,
          "R3 both words stored", {mem[8'h21], mem[8'h20], mem[8'h23], mem[8'h22]}, 32'h12345678);
  endtask

  task automatic t_wide_read_r6();
    logic [15:0] d; int cnt;
    host_read(16'h0020, 3, d, cnt);
    check(d == 16'h1234, "R6 byte order", d, 16'h1234);
    check(cnt == 6, "R5 miss after write", cnt, 6);
  endtask

  task automatic t_prefetch_r8();
    logic [15:0] d; int cnt;
    idle(10);
    host_read(16'h0022, 1, d, cnt);
    check(cnt == 1, "R8 sequential hit", cnt, 1);
    check(d == 16'h5678, "R8 prefetched data", d, 16'h5678);
  endtask

  task automatic t_other_r9();
    logic [15:0] d; int cnt;
    idle(10);
    other_access = 1; @(negedge clk); other_access = 0;
    host_read(16'h0024, 0, d, cnt);
    check(cnt == 6, "R9 invalidated by other access", cnt, 6);
    check(d == {ref_mem[8'h25], ref_mem[8'h24]}, "R9 data", d, {ref_mem[8'h25], ref_mem[8'h24]});
  endtask

  task automatic t_write_inval_r10();
    logic [15:0] d; int cnt;
    idle(10);
    host_write(16'h0026, 16'hBEEF, 1'b1, 1'b1, cnt);
    ref_mem[8'h26] = 8'hEF; ref_mem[8'h27] = 8'hBE;
    host_read(16'h0026, 0, d, cnt);
    check(d == 16'hBEEF, "R10 new data after write", d, 16'hBEEF);
    check(cnt > 1, "R10 buffer invalidated", cnt, 2);
  endtask

  task automatic t_nogrant_r4();
    int cnt;
    idle(10);
    arb_block = 1;
    host_addr = 16'h0040; host_rd = 1; host_sel = 1;
    repeat (8) @(negedge clk);
    check(!host_rdy && pb_req, "R4 stall without grant", {host_rdy, pb_req}, 2'b01);
    arb_block = 0;
    #1; cnt = 0;
    while (!host_rdy) begin @(negedge clk); cnt++; end
    check(host_rdata == {ref_mem[8'h41], ref_mem[8'h40]}, "R4 data after grant", host_rdata, {ref_mem[8'h41], ref_mem[8'h40]});
    check(cnt == 6, "R4 miss after grant", cnt, 6);
    @(negedge clk); host_rd = 0; host_sel = 0; @(negedge clk);
  endtask

  task automatic t_lanes_r12();
    int cnt;
    idle(10);
    host_write(16'h0031, 16'hA53C, 1'b1, 1'b1, cnt);
    host_write(16'h0040, 16'h7766, 1'b0, 1'b1, cnt);
    ref_mem[8'h31] = 8'hA5; ref_mem[8'h40] = 8'h66;
    idle(10);
    check(mem[8'h31] == 8'hA5 && mem[8'h30] == ref_mem[8'h30], "R12 odd lane only",
          {mem[8'h31], mem[8'h30]}, {8'hA5, ref_mem[8'h30]});
    check(mem[8'h40] == 8'h66 && mem[8'h41] == ref_mem[8'h41], "R12 even lane only",
          {mem[8'h41], mem[8'h40]}, {ref_mem[8'h41], 8'h66});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_unqualified_r1();
    t_narrow_read_r11();
    t_narrow_write_r2();
    t_stall_r3();
    t_wide_read_r6();
    t_prefetch_r8();
    t_other_r9();
    t_write_inval_r10();
    t_nogrant_r4();
    t_lanes_r12();
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule